// File: doc/BRIEF.md
# Boundary-Scan Test Access Port Controller

This block is the test access port for a memory device. It sits on its own test clock, which is independent of the memory clock. It runs the standard sixteen-state controller from the mode-select input and holds a 3-bit instruction. It steers one of three data registers between the serial input and the serial output. The three are a 1-bit bypass stage, a 32-bit identification word and a boundary chain of parameterised length. The boundary chain has a parallel capture port from the device pins and a parallel update latch that feeds them.

There is no dedicated test-reset pin. The controller starts in its reset state after power-up, released by `por_n`. It also returns there whenever the mode-select input stays high for five rising test-clock edges. From the active instruction the block produces two control outputs. One hands the pins to the update latch. The other forces every core output to high impedance.

Top module: `scan_tap_ctrl`

## Requirements
- R1: `tms` and `tdi` are sampled on the rising edge of `tck`, and `tdo`/`tdo_en` change only on the falling edge of `tck`.
- R2: After power-up (`por_n` low) the controller is in Test-Logic-Reset. From any state, five consecutive rising edges with `tms` high bring it to Test-Logic-Reset.
- R3: In Capture-IR the instruction shift stage loads 3'b001. It shifts out least significant bit first, giving 1, 0, 0 on `tdo`.
- R4: A shifted instruction becomes active only on entry to Update-IR. While in Exit1-IR, Pause-IR or Exit2-IR the previous instruction stays in force.
- R5: The active instruction is IDCODE (3'b001) after power-up and whenever Test-Logic-Reset is entered.
- R6: Under IDCODE, Capture-DR loads the 32-bit identification constant, whose bit 0 is forced to 1. Bit 0 reaches `tdo` first.
- R7: Codes 3'b000 (EXTEST), 3'b010 (SAMPLE-Z) and 3'b100 (SAMPLE/PRELOAD) select the boundary chain. Code 3'b111 (BYPASS) and the spare codes 3'b011, 3'b101 and 3'b110 select the 1-bit bypass stage, which captures 0.
- R8: Under a boundary instruction, Capture-DR loads `core_in[i]` where `PIN_MASK[i]` is 1, and 1 elsewhere. The chain shifts `tdi` into its top bit and bit 0 goes to `tdo`. On entry to Update-DR the chain is copied to `core_out`, which changes at no other time.
- R9: `tdo_en` is high only while the controller is in Shift-DR or Shift-IR.
- R10: `ext_drive` is high exactly while EXTEST is active, and `core_hiz` is high exactly while SAMPLE-Z is active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| por_n | input | 1 | Power-up reset, active low, asynchronous |
| tms | input | 1 | Mode select, sampled on rising `tck` |
| tdi | input | 1 | Serial data in, sampled on rising `tck` |
| core_in | input | BSR_LEN | Pin states offered to the boundary chain capture |
| tdo | output | 1 | Serial data out, updated on falling `tck` |
| tdo_en | output | 1 | High when `tdo` should be driven |
| core_out | output | BSR_LEN | Boundary update latch toward the pins |
| ext_drive | output | 1 | Pins take their values from `core_out` |
| core_hiz | output | 1 | Force all core outputs to high impedance |

## Verification
The embedded properties check on every edge a set of controller rules:
- the controller falls into Test-Logic-Reset after five high `tms` samples;
- the instruction changes only on entry to Update-IR or Test-Logic-Reset, and is IDCODE there;
- Capture-IR leaves 3'b001;
- `tdo_en` matches the shift states;
- the update latch moves only on entry to Update-DR.

The bench's scenarios show the data content:
- the identification stream and its bit order;
- the captured mix of pin values and fixed ones;
- the bypass delay under every bypass-mapped code;
- the pin-control outputs each instruction produces.

// File: rtl/scan_tap_ctrl.sv
module scan_tap_ctrl #(
  parameter int                 BSR_LEN  = 12,
  parameter logic [BSR_LEN-1:0] PIN_MASK = 12'h7DE,
  parameter logic [31:0]        ID_CODE  = 32'h2C51_9A4B
) (
  input  logic               tck,
  input  logic               por_n,
  input  logic               tms,
  input  logic               tdi,
  input  logic [BSR_LEN-1:0] core_in,
  output logic               tdo,
  output logic               tdo_en,
  output logic [BSR_LEN-1:0] core_out,
  output logic               ext_drive,
  output logic               core_hiz
);

  localparam int          IR_W    = 3;
  localparam logic [IR_W-1:0] OP_EXTEST = 3'b000;
  localparam logic [IR_W-1:0] OP_IDCODE = 3'b001;
  localparam logic [IR_W-1:0] OP_HIZSMP = 3'b010;
  localparam logic [IR_W-1:0] OP_SMPPRE = 3'b100;
  localparam logic [31:0]     ID_WORD = {ID_CODE[31:1], 1'b1};

  typedef enum logic [3:0] {
    ST_TLR, ST_RTI,
    ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
  } tap_st_e;

  typedef enum logic [1:0] {PATH_BYP, PATH_ID, PATH_BSR} path_e;

  tap_st_e            state, nxt;
  path_e              path;
  logic [IR_W-1:0]    ir_sh, ir_act;
  logic               byp;
  logic [31:0]        id_sh;
  logic [BSR_LEN-1:0] bsr_sh, bsr_upd, bsr_cap;
  logic               dr_lsb;

  always_comb begin
    unique case (state)
      ST_TLR:    nxt = tms ? ST_TLR    : ST_RTI;
      ST_RTI:    nxt = tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_DR: nxt = tms ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: nxt = tms ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  nxt = tms ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: nxt = tms ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: nxt = tms ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: nxt = tms ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: nxt = tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_IR: nxt = tms ? ST_TLR    : ST_CAP_IR;
      ST_CAP_IR: nxt = tms ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  nxt = tms ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: nxt = tms ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: nxt = tms ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: nxt = tms ? ST_UPD_IR : ST_SH_IR;
      default:   nxt = tms ? ST_SEL_DR : ST_RTI;
    endcase
  end

  always_comb begin
    unique case (ir_act)
      OP_EXTEST, OP_HIZSMP, OP_SMPPRE: path = PATH_BSR;
      OP_IDCODE:                       path = PATH_ID;
      default:                         path = PATH_BYP;
    endcase
  end

  assign bsr_cap = (core_in & PIN_MASK) | ~PIN_MASK;

  always_comb begin
    unique case (path)
      PATH_ID:  dr_lsb = id_sh[0];
      PATH_BSR: dr_lsb = bsr_sh[0];
      default:  dr_lsb = byp;
    endcase
  end

  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n) begin
      state   <= ST_TLR;
      ir_sh   <= '0;
      ir_act  <= OP_IDCODE;
      byp     <= 1'b0;
      id_sh   <= '0;
      bsr_sh  <= '0;
      bsr_upd <= '0;
    end else begin
      state <= nxt;
      if (state == ST_CAP_IR)     ir_sh <= 3'b001;
      else if (state == ST_SH_IR) ir_sh <= {tdi, ir_sh[IR_W-1:1]};
      if (nxt == ST_TLR)          ir_act <= OP_IDCODE;
      else if (nxt == ST_UPD_IR)  ir_act <= ir_sh;
      if (state == ST_CAP_DR) begin
        unique case (path)
          PATH_ID:  id_sh  <= ID_WORD;
          PATH_BSR: bsr_sh <= bsr_cap;
          default:  byp    <= 1'b0;
        endcase
      end else if (state == ST_SH_DR) begin
        unique case (path)
          PATH_ID:  id_sh  <= {tdi, id_sh[31:1]};
          PATH_BSR: bsr_sh <= {tdi, bsr_sh[BSR_LEN-1:1]};
          default:  byp    <= tdi;
        endcase
      end
      if (nxt == ST_UPD_DR && path == PATH_BSR) bsr_upd <= bsr_sh;
    end
  end

  always_ff @(negedge tck or negedge por_n) begin
    if (!por_n) begin
      tdo    <= 1'b0;
      tdo_en <= 1'b0;
    end else begin
      tdo    <= (state == ST_SH_IR) ? ir_sh[0] : dr_lsb;
      tdo_en <= (state == ST_SH_IR) || (state == ST_SH_DR);
    end
  end

  assign core_out  = bsr_upd;
  assign ext_drive = (ir_act == OP_EXTEST);
  assign core_hiz  = (ir_act == OP_HIZSMP);

  logic [2:0] tms_run;
  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n)   tms_run <= '0;
    else if (!tms) tms_run <= '0;
    else if (tms_run != 3'd5) tms_run <= tms_run + 3'd1;
  end

  assert_five_high_tlr_R2: assert property (@(posedge tck) disable iff (!por_n)
    (tms_run == 3'd5) |-> (state == ST_TLR));

  assert_ir_moves_on_update_R4: assert property (@(posedge tck) disable iff (!por_n)
    !$stable(ir_act) |-> (state == ST_UPD_IR || state == ST_TLR));

  assert_tlr_holds_idcode_R5: assert property (@(posedge tck) disable iff (!por_n)
    (state == ST_TLR) |-> (ir_act == OP_IDCODE));

  assert_capture_ir_pattern_R3: assert property (@(posedge tck) disable iff (!por_n)
    (state == ST_SH_IR && $past(state) == ST_CAP_IR) |-> (ir_sh == 3'b001));

  assert_tdo_en_shift_only_R9: assert property (@(posedge tck) disable iff (!por_n)
    tdo_en == (state == ST_SH_DR || state == ST_SH_IR));

  assert_latch_on_update_R8: assert property (@(posedge tck) disable iff (!por_n)
    !$stable(core_out) |-> (state == ST_UPD_DR));

  assert_extest_on_update_R10: assert property (@(posedge tck) disable iff (!por_n)
    $rose(ext_drive) |-> (state == ST_UPD_IR));

endmodule

// File: tb/scan_tap_ctrl_tb.sv
`timescale 1ns/100ps
module scan_tap_ctrl_tb_top;
  localparam int          BL   = 12;
  localparam logic [BL-1:0] MASK = 12'h7DE;
  localparam logic [31:0] IDW  = 32'h2C51_9A4B;

  logic          tck = 1'b0, por_n = 1'b0, tms = 1'b1, tdi = 1'b1;
  logic [BL-1:0] core_in = '0;
  logic          tdo, tdo_en, ext_drive, core_hiz;
  logic [BL-1:0] core_out;

  int    checks = 0, errors = 0;
  bit    done = 0;
  bit    exp_q[$];
  string req_q[$];

  always #2 tck = ~tck;

  scan_tap_ctrl #(.BSR_LEN(BL), .PIN_MASK(MASK), .ID_CODE(IDW)) dut_i (
    .tck(tck), .por_n(por_n), .tms(tms), .tdi(tdi), .core_in(core_in),
    .tdo(tdo), .tdo_en(tdo_en), .core_out(core_out),
    .ext_drive(ext_drive), .core_hiz(core_hiz));

  task automatic check(input string r, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", r, act, exp);
    end
  endtask

  task automatic push_bits(input string r, input logic [63:0] v, input int n);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(v[i]);
      req_q.push_back(r);
    end
  endtask

  // R1: tdo is read just after the rising edge; it must have settled at the prior falling edge
  always @(posedge tck) begin
    #1;
    if (por_n && tdo_en) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R9 actual tdo_en 1 expected no shift");
      end else begin
        automatic bit    e = exp_q.pop_front();
        automatic string r = req_q.pop_front();
        if (tdo !== e) begin
          errors++;
          $display("FAIL %s (R1) actual tdo %0b expected %0b", r, tdo, e);
        end
      end
    end
  end

  task automatic tick(input logic m, input logic d);
    @(negedge tck); #0.5;
    tms = m; tdi = d;
    @(posedge tck); #1;
  endtask

  task automatic shift_ir(input logic [2:0] code);
    tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
    push_bits("R3", 64'b001, 3);
    for (int i = 0; i < 3; i++) tick(i == 2, code[i]);
    tick(1, 0); tick(0, 0);
  endtask

  task automatic shift_dr(input string r, input int n, input logic [63:0] din, input logic [63:0] exp);
    tick(1, 0); tick(0, 0); tick(0, 0);
    push_bits(r, exp, n);
    for (int i = 0; i < n; i++) tick(i == n - 1, din[i]);
    tick(1, 0); tick(0, 0);
  endtask

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [2:0] spare [3];
    spare[0] = 3'b011; spare[1] = 3'b101; spare[2] = 3'b110;
    repeat (3) @(negedge tck);
    #0.5 por_n = 1'b1;
    #1;
    check("R2 reset tdo_en", tdo_en, 0);
    check("R10 reset ext_drive", ext_drive, 0);
    check("R10 reset core_hiz", core_hiz, 0);
    check("R8 reset core_out", core_out, 0);
    tick(0, 0);

    shift_dr("R6 (R5 default)", 32, 0, IDW);

    shift_ir(3'b111);
    shift_dr("R7 bypass", 4, 4'b1011, 4'b0110);

    foreach (spare[k]) begin
      shift_ir(spare[k]);
      shift_dr("R7 spare code", 2, 2'b01, 2'b10);
    end

    shift_ir(3'b100);
    check("R10 preload ext_drive", ext_drive, 0);
    core_in = 12'hA5C;
    shift_dr("R8 preload capture", BL, 12'h3C9, (12'hA5C & MASK) | ~MASK);
    check("R8 preload update", core_out, 12'h3C9);

    tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
    push_bits("R3", 64'b001, 3);
    tick(0, 0); tick(0, 0); tick(1, 0);
    tick(0, 0);
    check("R4 pause keeps old", ext_drive, 0);
    check("R9 pause tdo_en", tdo_en, 0);
    tick(1, 0);
    check("R4 exit2 keeps old", ext_drive, 0);
    tick(1, 0);
    check("R4 update applies", ext_drive, 1);
    check("R10 extest hiz", core_hiz, 0);
    tick(0, 0);

    core_in = 12'h1F0;
    shift_dr("R8 extest capture", BL, 12'h0A6, (12'h1F0 & MASK) | ~MASK);
    check("R8 extest update", core_out, 12'h0A6);

    shift_ir(3'b010);
    check("R10 samplez hiz", core_hiz, 1);
    check("R10 samplez drive", ext_drive, 0);
    check("R8 no update without DR", core_out, 12'h0A6);
    core_in = 12'h00F;
    shift_dr("R7 samplez chain", BL, 12'h555, (12'h00F & MASK) | ~MASK);
    check("R8 samplez update", core_out, 12'h555);

    tick(1, 0); tick(0, 0); tick(0, 0);
    push_bits("R8 cap lsb", 64'b1, 1);
    repeat (5) tick(1, 1);
    check("R5 tlr clears samplez", core_hiz, 0);
    check("R2 tlr tdo_en", tdo_en, 0);
    tick(0, 0);
    shift_dr("R5 id after tlr", 32, 0, IDW);

    repeat (2) tick(0, 0);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R9 actual %0d pending bits expected 0", exp_q.size());
    end
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule